// File: doc/BRIEF.md
# Busy Status Return Link

This block sits at the receiving end of a trigger link and keeps the trigger controller told whether the receiver can take more triggers. It merges a locally generated busy condition with the readout-busy line from the detector, packs the result into an 8-bit status word and sends that word continuously as 8b/10b symbols. The symbols are clocked by the five-times reference clock, so one reference period carries five symbols. Encoding a slowly varying level this way keeps the line DC balanced and gives the far end a framing marker.

The symbol stream is split into frames of five symbols. Each frame starts with a K28.5 comma and then carries the status word four times. The status word is captured once per frame, in the cycle that emits the comma. The same block also contains the matching decoder, which tracks running disparity, recovers the status word and the busy bit, and flags any symbol that is illegal under the current disparity. On such an error the decoder keeps the last good value. Serializers and line drivers are not part of the block.

Top module: `busy_return_link`

## Requirements
- R1: Every fifth symbol on `tx_code` is K28.5 (0011111010 or 1100000101), and the four symbols between two commas are data symbols.
- R2: Each data symbol carries the status word. Bit 0 is the busy flag, bit 1 is `ext_flag`, and bits 7..2 are zero.
- R3: The status word is captured only at the clock edge that emits a comma. Input changes between two such edges have no effect unless they are still present at the next capture edge. A pulse that begins and ends between captures never reaches `tx_code`.
- R4: Every symbol follows 8b/10b running disparity. The first six bits abcdei are at `tx_code[9:4]` and the last four bits fghj are at `tx_code[3:0]`. A symbol has five or six ones when disparity is negative, and four or five ones when it is positive. For example, status 0x00 after a negative-disparity comma is 0110001011.
- R5: A busy level on either input appears in the data symbols on `tx_code` within five reference clocks (25 symbol clocks). If the input is asserted just after a comma edge, the new data appears at the sixth edge.
- R6: The decoder updates `rx_status` and `rx_busy` at the edge that follows a legal data symbol on `rx_code`. A legal comma leaves both unchanged.
- R7: A symbol on `rx_code` that is not legal under the current running disparity raises `rx_err` for one cycle. It leaves `rx_status`, `rx_busy` and the decoder's running disparity unchanged.
- R8: While reset is held, `tx_code` is 0011111010, and `rx_status`, `rx_busy` and `rx_err` are zero.
- R9: The busy flag is the OR of `busy_local` and `busy_rdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Five-times reference clock (symbol clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_local | input | 1 | Busy condition raised on this board |
| busy_rdo | input | 1 | Readout-busy from the detector |
| ext_flag | input | 1 | Spare detector bit, carried as status bit 1 |
| tx_code | output | 10 | Outgoing 8b/10b symbol, abcdei in [9:4], fghj in [3:0] |
| rx_code | input | 10 | Incoming 8b/10b symbol for the decoder |
| rx_status | output | 8 | Last status word decoded without error |
| rx_busy | output | 1 | Bit 0 of `rx_status` |
| rx_err | output | 1 | One-cycle flag for an illegal or wrong-disparity symbol |

## Verification
In the decoder, a new status value and a corrupted symbol can arrive in the same cycle. The bench provokes this by changing the busy inputs so that the first data symbol carrying the new value is the one it overwrites with an illegal code on the loopback path. It then expects `rx_err` set and the old busy value held for that one cycle, with the new value taken from the next data symbol. On the transmit side, an input pulse that falls wholly between two capture edges is checked against a level that is held across the capture edge. Only the held level may reach the line.

// File: rtl/busy_link_pkg.sv
package busy_link_pkg;

  localparam logic [9:0] COMMA_NEG = 10'b0011111010;
  localparam logic [9:0] COMMA_POS = 10'b1100000101;

  typedef struct packed {
    logic       ok;
    logic       is_k;
    logic       rd_out;
    logic [7:0] data;
  } sym_dec_t;

  // 5b/6b code (abcdei) as sent with negative running disparity
  function automatic logic [5:0] six_neg(input logic [4:0] x);
    case (x)
      5'd0:  six_neg = 6'b100111;  5'd1:  six_neg = 6'b011101;
      5'd2:  six_neg = 6'b101101;  5'd3:  six_neg = 6'b110001;
      5'd4:  six_neg = 6'b110101;  5'd5:  six_neg = 6'b101001;
      5'd6:  six_neg = 6'b011001;  5'd7:  six_neg = 6'b111000;
      5'd8:  six_neg = 6'b111001;  5'd9:  six_neg = 6'b100101;
      5'd10: six_neg = 6'b010101;  5'd11: six_neg = 6'b110100;
      5'd12: six_neg = 6'b001101;  5'd13: six_neg = 6'b101100;
      5'd14: six_neg = 6'b011100;  5'd15: six_neg = 6'b010111;
      5'd16: six_neg = 6'b011011;  5'd17: six_neg = 6'b100011;
      5'd18: six_neg = 6'b010011;  5'd19: six_neg = 6'b110010;
      5'd20: six_neg = 6'b001011;  5'd21: six_neg = 6'b101010;
      5'd22: six_neg = 6'b011010;  5'd23: six_neg = 6'b111010;
      5'd24: six_neg = 6'b110011;  5'd25: six_neg = 6'b100110;
      5'd26: six_neg = 6'b010110;  5'd27: six_neg = 6'b110110;
      5'd28: six_neg = 6'b001110;  5'd29: six_neg = 6'b101110;
      5'd30: six_neg = 6'b011110;  default: six_neg = 6'b101011;
    endcase
  endfunction

  // 3b/4b code (fghj), negative disparity, primary x.7
  function automatic logic [3:0] four_neg(input logic [2:0] y);
    case (y)
      3'd0: four_neg = 4'b1011;  3'd1: four_neg = 4'b1001;
      3'd2: four_neg = 4'b0101;  3'd3: four_neg = 4'b1100;
      3'd4: four_neg = 4'b1101;  3'd5: four_neg = 4'b1010;
      3'd6: four_neg = 4'b0110;  default: four_neg = 4'b1110;
    endcase
  endfunction

  // returns {rd after 6b, abcdei}
  function automatic logic [6:0] enc_six(input logic [4:0] x, input logic rd);
    logic [5:0] c;
    logic       unbal;
    c     = six_neg(x);
    unbal = ($countones(c) != 3);
    if (rd && (unbal || x == 5'd7)) c = ~c;
    enc_six = {(unbal ? ~rd : rd), c};
  endfunction

  // returns {rd after 4b, fghj}
  function automatic logic [4:0] enc_four(input logic [2:0] y, input logic [4:0] x,
                                          input logic rd_mid);
    logic [3:0] c;
    logic       alt;
    logic       unbal;
    alt = (y == 3'd7) &&
          ((!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
           ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
    c     = alt ? 4'b0111 : four_neg(y);
    unbal = ($countones(c) != 2);
    if (rd_mid && (unbal || y == 3'd3)) c = ~c;
    enc_four = {(unbal ? ~rd_mid : rd_mid), c};
  endfunction

  // returns {rd after symbol, 10-bit code}
  function automatic logic [10:0] enc_data(input logic [7:0] d, input logic rd);
    logic [6:0] s;
    logic [4:0] f;
    s = enc_six(d[4:0], rd);
    f = enc_four(d[7:5], d[4:0], s[6]);
    enc_data = {f[4], s[5:0], f[3:0]};
  endfunction

  function automatic sym_dec_t dec_symbol(input logic [9:0] code, input logic rd);
    sym_dec_t   r;
    logic       hit6;
    logic [4:0] xs;
    logic       rdm;
    logic [6:0] t6;
    logic [4:0] t4;
    r    = '0;
    hit6 = 1'b0;
    xs   = '0;
    rdm  = rd;
    if (code == (rd ? COMMA_POS : COMMA_NEG)) begin
      r.ok     = 1'b1;
      r.is_k   = 1'b1;
      r.rd_out = ~rd;
    end else begin
      for (int i = 0; i < 32; i++) begin
        t6 = enc_six(5'(i), rd);
        if (!hit6 && t6[5:0] == code[9:4]) begin
          hit6 = 1'b1;
          xs   = 5'(i);
          rdm  = t6[6];
        end
      end
      if (hit6) begin
        for (int j = 0; j < 8; j++) begin
          t4 = enc_four(3'(j), xs, rdm);
          if (!r.ok && t4[3:0] == code[3:0]) begin
            r.ok     = 1'b1;
            r.rd_out = t4[4];
            r.data   = {3'(j), xs};
          end
        end
      end
    end
    dec_symbol = r;
  endfunction

endpackage

// File: rtl/busy_slot_timer.sv
module busy_slot_timer #(
  parameter int SLOTS = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic slot_zero
);
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic [SW-1:0] slot_q;

  // reset leaves the comma already on the line, so the next slot is 1
  always_ff @(posedge clk) begin
    if (!rst_n)              slot_q <= SW'(1 % SLOTS);
    else if (slot_q == LAST) slot_q <= '0;
    else                     slot_q <= slot_q + 1'b1;
  end

  assign slot_zero = (slot_q == '0);

  assert_slot_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= LAST);
endmodule

// File: rtl/busy_sym_encoder.sv
module busy_sym_encoder
  import busy_link_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       send_comma,
  input  logic [7:0] octet,
  output logic [9:0] code_q
);
  logic        rd_q;
  logic [10:0] enc_w;

  assign enc_w = enc_data(octet, rd_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= COMMA_NEG;
      rd_q   <= 1'b1;
    end else if (send_comma) begin
      code_q <= rd_q ? COMMA_POS : COMMA_NEG;
      rd_q   <= ~rd_q;
    end else begin
      code_q <= enc_w[9:0];
      rd_q   <= enc_w[10];
    end
  end

  assert_weight_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_q |=> ($countones(code_q) == 5 || $countones(code_q) == 6));
  assert_weight_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |=> ($countones(code_q) == 4 || $countones(code_q) == 5));
  assert_comma_R1: assert property (@(posedge clk) disable iff (!rst_n)
    send_comma |=> (code_q == COMMA_NEG || code_q == COMMA_POS));
endmodule

// File: rtl/busy_sym_decoder.sv
module busy_sym_decoder
  import busy_link_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [9:0] code_in,
  output logic [7:0] status_q,
  output logic       err_q
);
  logic     rd_q;
  sym_dec_t res;
  logic     sym_bad;
  logic     sym_comma;

  assign res       = dec_symbol(code_in, rd_q);
  assign sym_bad   = !res.ok;
  assign sym_comma = res.ok && res.is_k;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q     <= 1'b0;
      status_q <= '0;
      err_q    <= 1'b0;
    end else if (sym_bad) begin
      err_q <= 1'b1;
    end else begin
      err_q <= 1'b0;
      rd_q  <= res.rd_out;
      if (!res.is_k) status_q <= res.data;
    end
  end

  assert_hold_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sym_bad |=> (err_q && $stable(status_q) && $stable(rd_q)));
  assert_comma_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sym_comma |=> (!err_q && $stable(status_q)));
endmodule

// File: rtl/busy_return_link.sv
module busy_return_link #(
  parameter int SLOTS_PER_REF = 5,
  parameter int DEADLINE_REF  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy_local,
  input  logic       busy_rdo,
  input  logic       ext_flag,
  output logic [9:0] tx_code,
  input  logic [9:0] rx_code,
  output logic [7:0] rx_status,
  output logic       rx_busy,
  output logic       rx_err
);
  localparam int LIMIT = SLOTS_PER_REF * DEADLINE_REF;
  localparam int CW    = $clog2(LIMIT + 2) + 1;

  logic          frame_start;
  logic [7:0]    status_q;
  logic          busy_req;
  logic          line_busy_q;
  logic [CW-1:0] wait_cnt;

  assign busy_req = busy_local | busy_rdo;

  busy_slot_timer #(.SLOTS(SLOTS_PER_REF)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_zero (frame_start)
  );

  // status word captured once per frame, at the comma slot
  always_ff @(posedge clk) begin
    if (!rst_n)           status_q <= '0;
    else if (frame_start) status_q <= {6'b0, ext_flag, busy_req};
  end

  busy_sym_encoder u_enc (
    .clk        (clk),
    .rst_n      (rst_n),
    .send_comma (frame_start),
    .octet      (status_q),
    .code_q     (tx_code)
  );

  busy_sym_decoder u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_in  (rx_code),
    .status_q (rx_status),
    .err_q    (rx_err)
  );

  assign rx_busy = rx_status[0];

  // busy bit of the latest data symbol put on the line, and the
  // count of cycles a requested busy has waited for it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_busy_q <= 1'b0;
      wait_cnt    <= '0;
    end else begin
      if (!frame_start) line_busy_q <= status_q[0];
      if (busy_req && !line_busy_q)
        wait_cnt <= (wait_cnt > CW'(LIMIT)) ? wait_cnt : wait_cnt + 1'b1;
      else
        wait_cnt <= '0;
    end
  end

  assert_busy_deadline_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= CW'(LIMIT));
  assert_sample_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(status_q));
  assert_or_merge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (status_q[0] == $past(busy_local | busy_rdo)));
endmodule

// File: tb/busy_return_link_test.sv
module busy_return_link_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] KN = 10'b0011111010;
  localparam logic [9:0] KP = 10'b1100000101;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busy_local = 1'b0, busy_rdo = 1'b0, ext_flag = 1'b0;
  logic       inj = 1'b0;
  logic [9:0] tx_code, rx_code;
  logic [7:0] rx_status;
  logic       rx_busy, rx_err;

  int checks = 0, errors = 0;
  int r1_bad = 0, r4_bad = 0;
  logic rd_b, rd_prev;
  int   since_k;

  assign rx_code = inj ? 10'h3FF : tx_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  busy_return_link uut (
    .clk(clk), .rst_n(rst_n), .busy_local(busy_local), .busy_rdo(busy_rdo),
    .ext_flag(ext_flag), .tx_code(tx_code), .rx_code(rx_code),
    .rx_status(rx_status), .rx_busy(rx_busy), .rx_err(rx_err)
  );

  // R4 expected codes: status 0x00 and 0x01, from the standard code table
  function automatic logic [9:0] exp_sym(input logic [7:0] oct, input logic rd);
    if (oct == 8'h00) exp_sym = rd ? 10'b0110001011 : 10'b1001110100;
    else              exp_sym = rd ? 10'b1000101011 : 10'b0111010100;
  endfunction

  function automatic logic is_k(input logic [9:0] c);
    is_k = (c == KN) || (c == KP);
  endfunction

  // stream monitor: comma spacing (R1) and disparity (R4)
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_b = 1'b1; rd_prev = 1'b0; since_k = 0;
    end else begin
      int n;
      n = $countones(tx_code);
      if (is_k(tx_code)) begin
        if (since_k != 4) r1_bad++;
        since_k = 0;
      end else begin
        since_k++;
        if (since_k > 4) r1_bad++;
      end
      if (!rd_b && !(n == 5 || n == 6)) r4_bad++;
      if ( rd_b && !(n == 4 || n == 5)) r4_bad++;
      rd_prev = rd_b;
      if (n > 5) rd_b = 1'b1;
      else if (n < 5) rd_b = 1'b0;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  // returns just after the edge that put a comma on tx_code
  task automatic wait_comma();
    do step(); while (!is_k(tx_code));
  endtask

  task automatic settle();
    repeat (12) step();
  endtask

  task automatic t_reset();
    repeat (3) step();
    chk(tx_code == KN, "R8 tx_code", tx_code, KN);
    chk(rx_status == 8'h00 && !rx_busy, "R8 rx_status", rx_status, 0);
    chk(!rx_err, "R8 rx_err", rx_err, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_idle();
    wait_comma();
    for (int k = 1; k <= 4; k++) begin
      step();
      chk(tx_code == exp_sym(8'h00, rd_prev), "R2/R4 idle data symbol", tx_code,
          exp_sym(8'h00, rd_prev));
    end
    chk(rx_status == 8'h00, "R6 idle rx_status", rx_status, 0);
  endtask

  task automatic t_busy_rise();
    wait_comma();
    busy_local = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      step();
      chk(tx_code == exp_sym(8'h00, rd_prev), "R3 old status kept in frame", tx_code,
          exp_sym(8'h00, rd_prev));
    end
    step();
    chk(is_k(tx_code), "R1 comma at frame start", tx_code, KN);
    step();
    chk(tx_code == exp_sym(8'h01, rd_prev), "R5 busy on line at sixth edge", tx_code,
        exp_sym(8'h01, rd_prev));
    chk(!rx_busy, "R6 rx_busy not yet updated", rx_busy, 0);
    step();
    chk(rx_busy && rx_status == 8'h01, "R6 rx_busy after data symbol", rx_status, 1);
  endtask

  task automatic t_release_and_pulse();
    busy_local = 1'b0;
    settle();
    chk(!rx_busy, "R6 busy released", rx_busy, 0);
    wait_comma();
    step();
    busy_rdo = 1'b1;
    step(); step();
    busy_rdo = 1'b0;
    for (int k = 0; k < 8; k++) begin
      step();
      if (!is_k(tx_code))
        chk(tx_code == exp_sym(8'h00, rd_prev), "R3 mid-frame pulse ignored", tx_code,
            exp_sym(8'h00, rd_prev));
    end
    chk(!rx_busy, "R3 pulse never decoded", rx_busy, 0);
  endtask

  task automatic t_or_merge();
    busy_rdo = 1'b1;
    settle();
    chk(rx_busy && rx_status == 8'h01, "R9 readout busy alone", rx_status, 1);
    ext_flag = 1'b1;
    settle();
    chk(rx_status == 8'h03, "R2 spare bit in position 1", rx_status, 3);
    ext_flag = 1'b0;
    busy_rdo = 1'b0;
    busy_local = 1'b1;
    settle();
    chk(rx_status == 8'h01, "R9 local busy alone", rx_status, 1);
  endtask

  task automatic t_error_hold();
    int extra;
    wait_comma();
    step(); step();
    inj = 1'b1;
    step();
    inj = 1'b0;
    chk(rx_err, "R7 error flagged", rx_err, 1);
    chk(rx_busy && rx_status == 8'h01, "R7 busy held on error", rx_status, 1);
    extra = 0;
    for (int k = 0; k < 10; k++) begin
      step();
      if (rx_err) extra++;
    end
    chk(extra == 0, "R7 one-cycle flag, disparity kept", extra, 0);
  endtask

  task automatic t_collide();
    wait_comma();
    busy_local = 1'b0;
    repeat (6) step();
    inj = 1'b1;
    step();
    inj = 1'b0;
    chk(rx_err && rx_busy, "R7 corrupted first new symbol holds old busy", rx_busy, 1);
    step();
    chk(!rx_err && !rx_busy, "R6 next data symbol delivers new busy", rx_busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", 200000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_busy_rise();
    t_release_and_pulse();
    t_or_merge();
    t_error_hold();
    t_collide();
    settle();
    chk(r1_bad == 0, "R1 comma spacing", r1_bad, 0);
    chk(r4_bad == 0, "R4 running disparity", r4_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule